// File: doc/BRIEF.md
# Converter Bus Interface Sequencer

This block is the control logic that sits between a microprocessor bus and a sampling analog-to-digital datapath. The host sees three active-low strobes: chip select, sample and read. The block times the sample, coarse and fine phases of each conversion with its own cycle counter. It takes the finished result from the datapath over a valid/ready handshake. It then pulls an active-low interrupt and presents the latched word on a 10-bit bus. That bus is modelled as a data output plus an output enable for a pad-level tri-state driver.

Two host interface styles share one sequencer. The style is chosen by a static configuration pin that is captured only while reset is held.

- **Split style.** The sample strobe alone starts the conversion. The host holds the sample strobe low for as long as it wants the input tracked. The rising edge of the sample strobe ends tracking, with a minimum tracking time enforced internally. The host fetches the word later with a separate read strobe.
- **Tied style.** The host wires the sample and read strobes together. Pulling them low starts a conversion, and the internal timer alone ends tracking. The bus is driven for the whole time the lines are low, but it shows the new word only once the interrupt has fallen.

In both styles the interrupt is cleared by the end of a gated read, not by any register access.

The result port follows these rules. `res_ready` is high only in the cycle(s) where the sequencer waits for a result. A word is taken on a clock edge where both `res_valid` and `res_ready` are high. The datapath may hold `res_valid` low for any number of cycles, and the sequencer simply waits. A `res_valid` seen while `res_ready` is low is dropped. All host pins are treated as synchronous to `clk`.

Top module: `cvt_bus_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `int_n`=1, `db_oe`=0, `smp_o`=`fine_o`=`res_ready`=0 and `db_o`=0. The level of `mode_tied_i` (0 = split, 1 = tied) is captured on the clock edges where `rst_n` is low.
- R2: While `cs_n`=1, activity on `sh_n` and `rd_n` starts no conversion and never asserts `db_oe`. The gated sample request is `!cs_n && !sh_n`, and the gated read is `!cs_n && !rd_n`.
- R3: In split style, `smp_o` rises on the second clock edge after the gated sample request is first sampled true. It stays high for max(H, SMP_MIN_CYC) cycles, where H is the number of edges at which the request was sampled true. `crs_lat_o` is high in the last of those cycles.
- R4: `fine_o` is high for exactly FINE_CYC cycles directly after the sample phase. `res_ready` rises in the following cycle.
- R5: In tied style, `smp_o` stays high for exactly CRS2_CYC cycles, whatever the strobes do during that time.
- R6: `res_ready` is high only while the sequencer waits for a result. A word is latched on an edge where `res_valid` and `res_ready` are both high. Any wait before `res_valid` is tolerated. `res_valid` while `res_ready` is low has no effect.
- R7: `int_n` goes low on the edge after the edge that accepts a result. It goes high on the second edge after the gated read is first sampled false following a sample where it was true. Acceptance wins if both happen on one edge.
- R8: `db_oe` equals the gated read as sampled on the previous edge, so either `rd_n` or `cs_n` rising releases the bus. `db_o` always carries the last accepted word. In tied style it therefore shows the previous word during a conversion.
- R9: A gated sample falling edge that arrives while a conversion is in progress is ignored and not remembered.
- R10: Changing `mode_tied_i` after reset has no effect until the next reset.
- R11: A new conversion needs a fresh falling edge of the gated sample request. Holding it low after a conversion completes starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_tied_i | input | 1 | Interface style, captured in reset: 0 split, 1 tied |
| cs_n | input | 1 | Active-low chip select |
| sh_n | input | 1 | Active-low sample request |
| rd_n | input | 1 | Active-low read strobe |
| int_n | output | 1 | Active-low conversion-complete interrupt |
| db_o | output | DW | Latched conversion word for the bus pads |
| db_oe | output | 1 | Bus pad output enable (0 = high impedance) |
| smp_o | output | 1 | Datapath tracks the input (sample phase) |
| crs_lat_o | output | 1 | Last sample cycle: datapath latches coarse result |
| fine_o | output | 1 | Datapath fine phase in progress |
| res_ready | output | 1 | Sequencer can take a result word |
| res_valid | input | 1 | Datapath offers a result word |
| res_data | input | DW | Result word from the datapath |

## Verification
The bench goes after the following corner cases.

- **Short sample strobe.** A split-style sample strobe shorter than the minimum is sent. A design that honoured the raw strobe would cut tracking short and latch the coarse result early.
- **Tied lines released early, and held low afterwards.** In tied style the lines are released early, and later held low past completion. A sequencer that followed the strobes, or re-armed on level, would end tracking at the wrong time or restart on its own.
- **Sample falling edge mid-conversion.** A second falling edge of the sample strobe arrives during the fine phase. A design that queued it would run an extra conversion.
- **Stalled result and stray valid.** The result is stalled, and a stray valid pulse arrives before ready. Accepting that pulse would latch a wrong word.
- **Chip select deasserted during a read.** The read is ended by chip select instead of the read strobe. A design that watched only `rd_n` would leave the bus driven and the interrupt stuck low.

// File: rtl/cvt_bus_seq_pkg.sv
package cvt_bus_seq_pkg;

  // Conversion phases seen by the datapath.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_FINE   = 2'd2,
    PH_RESULT = 2'd3
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cvt_bus_seq_pins.sv
// Registers the host strobes once, applies the chip-select gating and
// finds the edges of the gated sample and read requests.
module cvt_bus_seq_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sh_n,
  input  logic rd_n,
  output logic smp_req,
  output logic smp_fall,
  output logic rd_act,
  output logic rd_rise
);

  logic cs_q, sh_q, rd_q;
  logic smp_req_d, rd_act_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      sh_q <= 1'b1;
      rd_q <= 1'b1;
      smp_req_d <= 1'b0;
      rd_act_d  <= 1'b0;
    end else begin
      cs_q <= cs_n;
      sh_q <= sh_n;
      rd_q <= rd_n;
      smp_req_d <= smp_req;
      rd_act_d  <= rd_act;
    end
  end

  assign smp_req  = !cs_q && !sh_q;
  assign rd_act   = !cs_q && !rd_q;
  assign smp_fall = smp_req && !smp_req_d;
  assign rd_rise  = rd_act_d && !rd_act;

endmodule

// File: rtl/cvt_bus_seq_timer.sv
// Phase sequencer: sample, fine and result-wait phases timed by one counter.
module cvt_bus_seq_timer
  import cvt_bus_seq_pkg::*;
#(
  parameter int SMP_MIN_CYC = 25,
  parameter int CRS2_CYC    = 60,
  parameter int FINE_CYC    = 120
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   mode_tied,
  input  logic   smp_req,
  input  logic   smp_fall,
  input  logic   res_valid,
  output phase_e phase,
  output logic   crs_lat,
  output logic   accept
);

  localparam int MAXC = max3(SMP_MIN_CYC, CRS2_CYC, FINE_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SMP_LAST  = CW'(SMP_MIN_CYC - 1);
  localparam logic [CW-1:0] CRS2_LAST = CW'(CRS2_CYC - 1);
  localparam logic [CW-1:0] FINE_LAST = CW'(FINE_CYC - 1);
  localparam logic [CW-1:0] CNT_CAP   = CW'(MAXC - 1);

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          leave_smp;

  // Split style waits for release and the minimum; tied style uses the timer only.
  always_comb begin
    if (mode_tied) leave_smp = (cnt == CRS2_LAST);
    else           leave_smp = !smp_req && (cnt >= SMP_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (smp_fall) begin
            ph  <= PH_SAMPLE;
            cnt <= '0;
          end
        end
        PH_SAMPLE: begin
          if (leave_smp) begin
            ph  <= PH_FINE;
            cnt <= '0;
          end else if (cnt != CNT_CAP) begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_FINE: begin
          if (cnt == FINE_LAST) begin
            ph  <= PH_RESULT;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_RESULT: begin
          if (res_valid) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign phase   = ph;
  assign crs_lat = (ph == PH_SAMPLE) && leave_smp;
  assign accept  = (ph == PH_RESULT) && res_valid;

endmodule

// File: rtl/cvt_bus_seq_result.sv
// Output word register and interrupt flag.
module cvt_bus_seq_result #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] res_data,
  input  logic          rd_rise,
  output logic [DW-1:0] word_q,
  output logic          int_n
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      int_n  <= 1'b1;
    end else begin
      if (accept) word_q <= res_data;
      // A completing conversion outranks a read ending on the same edge.
      if (accept)       int_n <= 1'b0;
      else if (rd_rise) int_n <= 1'b1;
    end
  end

endmodule

// File: rtl/cvt_bus_seq.sv
module cvt_bus_seq
  import cvt_bus_seq_pkg::*;
#(
  parameter int DW          = 10,
  parameter int SMP_MIN_CYC = 25,
  parameter int CRS2_CYC    = 60,
  parameter int FINE_CYC    = 120
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_tied_i,
  input  logic          cs_n,
  input  logic          sh_n,
  input  logic          rd_n,
  output logic          int_n,
  output logic [DW-1:0] db_o,
  output logic          db_oe,
  output logic          smp_o,
  output logic          crs_lat_o,
  output logic          fine_o,
  output logic          res_ready,
  input  logic          res_valid,
  input  logic [DW-1:0] res_data
);

  logic   mode_tied_q;
  logic   smp_req, smp_fall, rd_act, rd_rise;
  logic   accept;
  phase_e phase;

  // Interface style is only taken while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) mode_tied_q <= mode_tied_i;
  end

  cvt_bus_seq_pins u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sh_n     (sh_n),
    .rd_n     (rd_n),
    .smp_req  (smp_req),
    .smp_fall (smp_fall),
    .rd_act   (rd_act),
    .rd_rise  (rd_rise)
  );

  cvt_bus_seq_timer #(
    .SMP_MIN_CYC (SMP_MIN_CYC),
    .CRS2_CYC    (CRS2_CYC),
    .FINE_CYC    (FINE_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_tied (mode_tied_q),
    .smp_req   (smp_req),
    .smp_fall  (smp_fall),
    .res_valid (res_valid),
    .phase     (phase),
    .crs_lat   (crs_lat_o),
    .accept    (accept)
  );

  cvt_bus_seq_result #(
    .DW (DW)
  ) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .res_data (res_data),
    .rd_rise  (rd_rise),
    .word_q   (db_o),
    .int_n    (int_n)
  );

  assign db_oe     = rd_act;
  assign smp_o     = (phase == PH_SAMPLE);
  assign fine_o    = (phase == PH_FINE);
  assign res_ready = (phase == PH_RESULT);

endmodule

// File: rtl/cvt_bus_seq_chk.sv
module cvt_bus_seq_chk #(
  parameter int DW          = 10,
  parameter int SMP_MIN_CYC = 25,
  parameter int CRS2_CYC    = 60,
  parameter int FINE_CYC    = 120
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_tied_q,
  input logic          cs_n,
  input logic          rd_n,
  input logic          int_n,
  input logic [DW-1:0] db_o,
  input logic          db_oe,
  input logic          smp_o,
  input logic          crs_lat_o,
  input logic          fine_o,
  input logic          res_ready,
  input logic          res_valid
);

  int smp_run, fine_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_run  <= 0;
      fine_run <= 0;
    end else begin
      smp_run  <= smp_o  ? smp_run + 1  : 0;
      fine_run <= fine_o ? fine_run + 1 : 0;
    end
  end

  assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_o, fine_o, res_ready}));

  assert_int_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !int_n);

  assert_int_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> (!$past(db_oe) && $past(db_oe, 2)));

  assert_bus_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (db_oe == (!$past(cs_n) && !$past(rd_n))));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_valid && res_ready) |=> $stable(db_o));

  assert_sample_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(smp_o) && !mode_tied_q) |-> (smp_run >= SMP_MIN_CYC));

  assert_sample_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(smp_o) && mode_tied_q) |-> (smp_run == CRS2_CYC));

  assert_coarse_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crs_lat_o |=> (fine_o && !smp_o));

  assert_fine_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fine_o) |-> (res_ready && fine_run == FINE_CYC));

endmodule

bind cvt_bus_seq cvt_bus_seq_chk #(
  .DW          (DW),
  .SMP_MIN_CYC (SMP_MIN_CYC),
  .CRS2_CYC    (CRS2_CYC),
  .FINE_CYC    (FINE_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_tied_q (mode_tied_q),
  .cs_n        (cs_n),
  .rd_n        (rd_n),
  .int_n       (int_n),
  .db_o        (db_o),
  .db_oe       (db_oe),
  .smp_o       (smp_o),
  .crs_lat_o   (crs_lat_o),
  .fine_o      (fine_o),
  .res_ready   (res_ready),
  .res_valid   (res_valid)
);

// File: tb/cvt_bus_seq_test.sv
module cvt_bus_seq_test;
  localparam int DW  = 10;
  localparam int SMP = 25;
  localparam int CRS = 60;
  localparam int FIN = 120;

  logic clk = 1'b0, rst_n = 1'b0, mode_cfg = 1'b0;
  logic cs_n = 1'b1, sh_n = 1'b1, rd_n = 1'b1, res_valid = 1'b0;
  logic [DW-1:0] res_data = '0;
  logic int_n, db_oe, smp_o, crs_lat_o, fine_o, res_ready;
  logic [DW-1:0] db_o;

  int tests = 0, fails = 0, cycles = 0;

  // stimulus for the result responder
  int resp_data = 0, stall = 0, wcnt = 0;
  bit spur = 0;

  // monitors
  int smp_run = 0, last_smp = 0, fine_run = 0, last_fine = 0, starts = 0, oe_cycles = 0;
  bit smp_prev = 0;

  // behavioural reference state
  int m_phase = 0, m_held = 0, m_left = 0, m_int = 1, m_data = 0, m_mode = 0;
  bit s1 = 0, s2 = 0, r1 = 0, r2 = 0;

  always #5 clk = ~clk;

  cvt_bus_seq #(.DW(DW), .SMP_MIN_CYC(SMP), .CRS2_CYC(CRS), .FINE_CYC(FIN)) uut (
    .clk(clk), .rst_n(rst_n), .mode_tied_i(mode_cfg),
    .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n),
    .int_n(int_n), .db_o(db_o), .db_oe(db_oe),
    .smp_o(smp_o), .crs_lat_o(crs_lat_o), .fine_o(fine_o),
    .res_ready(res_ready), .res_valid(res_valid), .res_data(res_data)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    bit fall, rrise, done;
    if (!rst_n) begin
      m_mode = mode_cfg; m_phase = 0; m_held = 0; m_left = 0;
      m_int = 1; m_data = 0; s1 = 0; s2 = 0; r1 = 0; r2 = 0;
    end else begin
      fall = s1 && !s2;
      rrise = r2 && !r1;
      done = 0;
      case (m_phase)
        0: if (fall) begin m_phase = 1; m_held = 0; end
        1: begin
          m_held++;
          if (m_mode != 0 ? (m_held == CRS) : (!s1 && m_held >= SMP)) begin
            m_phase = 2; m_left = FIN;
          end
        end
        2: begin m_left--; if (m_left == 0) m_phase = 3; end
        default: if (res_valid) begin m_data = int'(res_data); done = 1; m_phase = 0; end
      endcase
      if (done) m_int = 0;
      else if (rrise) m_int = 1;
      s2 = s1; s1 = !cs_n && !sh_n;
      r2 = r1; r1 = !cs_n && !rd_n;
    end
  end

  // per-cycle comparison and monitors
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7", "int_n", int'(int_n), m_int);
      check("R8", "db_oe", int'(db_oe), int'(r1));
      check("R8", "db_o", int'(db_o), m_data);
      check("R6", "res_ready", int'(res_ready), int'(m_phase == 3));
      check(m_mode != 0 ? "R5" : "R3", "smp_o", int'(smp_o), int'(m_phase == 1));
      check("R4", "fine_o", int'(fine_o), int'(m_phase == 2));
      if (smp_o && !smp_prev) starts++;
      smp_prev = smp_o;
      if (smp_o) smp_run++;
      else if (smp_run != 0) begin last_smp = smp_run; smp_run = 0; end
      if (fine_o) fine_run++;
      else if (fine_run != 0) begin last_fine = fine_run; fine_run = 0; end
      if (db_oe) oe_cycles++;
    end
  end

  // datapath responder
  always @(negedge clk) begin
    if (!rst_n) begin
      res_valid = 0; wcnt = 0;
    end else if (res_valid) begin
      res_valid = 0;
    end else if (spur && fine_o) begin
      res_valid = 1; res_data = DW'(~resp_data); spur = 0;
    end else if (res_ready) begin
      if (wcnt >= stall) begin
        res_valid = 1; res_data = DW'(resp_data); wcnt = 0;
      end else wcnt++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset(input logic md);
    @(negedge clk);
    rst_n = 0; mode_cfg = md; cs_n = 1; sh_n = 1; rd_n = 1;
    settle(5);
    @(negedge clk);
    rst_n = 1;
    smp_run = 0; fine_run = 0; smp_prev = 0;
  endtask

  task automatic wait_int_low(input string req);
    int n = 0;
    while (int_n !== 1'b0 && n < 3000) begin @(negedge clk); n++; end
    #1;
    check(req, "int_n fell", int'(int_n), 0);
  endtask

  initial begin
    int st0;
    do_reset(1'b0);
    settle(1);
    // R1: reset state
    check("R1", "int_n after reset", int'(int_n), 1);
    check("R1", "db_oe after reset", int'(db_oe), 0);
    check("R1", "res_ready after reset", int'(res_ready), 0);
    check("R1", "smp_o after reset", int'(smp_o), 0);
    check("R1", "db_o after reset", int'(db_o), 0);

    // R2: strobes with chip select high
    cs_n = 1; sh_n = 0; rd_n = 0;
    settle(40);
    check("R2", "starts with cs high", starts, 0);
    check("R2", "bus cycles with cs high", oe_cycles, 0);
    sh_n = 1; rd_n = 1;
    settle(5);

    // R3/R4: split-style conversion with long sample
    resp_data = 'h2A5; stall = 0;
    cs_n = 0; sh_n = 0;
    settle(30);
    sh_n = 1;
    wait_int_low("R4");
    settle(2);
    check("R3", "long sample length", last_smp, 30);
    check("R4", "fine length", last_fine, FIN);
    rd_n = 0;
    settle(3);
    check("R8", "bus enabled on read", int'(db_oe), 1);
    check("R8", "word on read", int'(db_o), 'h2A5);
    rd_n = 1;
    settle(1);
    check("R8", "bus released after read", int'(db_oe), 0);
    check("R7", "int_n one edge after release", int'(int_n), 0);
    settle(1);
    check("R7", "int_n two edges after release", int'(int_n), 1);

    // R3/R6: short sample, stalled result, stray valid
    resp_data = 'h3FF; stall = 7; spur = 1;
    sh_n = 0;
    settle(5);
    sh_n = 1;
    wait_int_low("R6");
    settle(2);
    check("R3", "short sample stretched", last_smp, SMP);
    rd_n = 0;
    settle(3);
    check("R6", "word after stall and stray valid", int'(db_o), 'h3FF);
    cs_n = 1;
    settle(1);
    check("R8", "bus released by chip select", int'(db_oe), 0);
    settle(1);
    check("R7", "int_n cleared by chip select", int'(int_n), 1);
    rd_n = 1; cs_n = 0;
    settle(3);

    // R9: second sample edge during the fine phase
    resp_data = 'h000; stall = 2; st0 = starts;
    sh_n = 0;
    settle(30);
    sh_n = 1;
    while (fine_o !== 1'b1) @(negedge clk);
    sh_n = 0;
    settle(20);
    sh_n = 1;
    wait_int_low("R9");
    settle(40);
    check("R9", "single start for two edges", starts, st0 + 1);
    check("R9", "idle after busy edge", int'(smp_o), 0);
    rd_n = 0;
    settle(3);
    check("R9", "word of the one conversion", int'(db_o), 'h000);
    rd_n = 1;
    settle(3);

    // tied style; R10: config changed after reset
    do_reset(1'b1);
    mode_cfg = 0;
    resp_data = 'h155; stall = 1;
    cs_n = 0; sh_n = 0; rd_n = 0;
    settle(CRS + 10);
    check("R8", "bus driven during tied conversion", int'(db_oe), 1);
    check("R8", "old word during tied conversion", int'(db_o), 0);
    wait_int_low("R5");
    settle(2);
    check("R5", "tied sample length", last_smp, CRS);
    check("R10", "style kept after config change", int'(smp_o), 0);
    check("R8", "new word after interrupt", int'(db_o), 'h155);
    st0 = starts;
    settle(40);
    check("R11", "no restart while held low", starts, st0);
    check("R11", "idle while held low", int'(smp_o), 0);
    sh_n = 1; rd_n = 1;
    settle(2);
    check("R7", "int_n after tied release", int'(int_n), 1);

    // R5: tied lines released early, timer still decides
    resp_data = 'h0AA; stall = 0;
    sh_n = 0; rd_n = 0;
    settle(10);
    check("R8", "previous word early in conversion", int'(db_o), 'h155);
    sh_n = 1; rd_n = 1;
    wait_int_low("R5");
    settle(2);
    check("R5", "tied sample length after early release", last_smp, CRS);
    sh_n = 0; rd_n = 0;
    settle(10);
    check("R8", "word from early-release conversion", int'(db_o), 'h0AA);
    wait_int_low("R7");
    sh_n = 1; rd_n = 1;
    settle(5);

    finish_run();
  end
endmodule